// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block merges five interrupt request lines into a single interrupt output for a processor. Each line is first brought into the local clock domain by a two-flop synchronizer. It is then inverted or passed through according to its own polarity bit. It is then either used directly as a level or fed to an edge detector whose sticky latch carries the request. A per-line enable masks the result, and the OR of the surviving requests, registered once, drives the output.

Software reaches the block through a simple 32-bit register port with a write strobe and a combinational read path. Enables can be written as a whole word, or changed bit by bit through a write-one-to-set alias and a write-one-to-clear alias. Edge latches are cleared by writing ones to an acknowledge alias. Two offsets serve double duty: a read returns a status word and a write issues a command. A read-only options word gives the number of inputs. A read-only version word carries an identifier together with its bitwise complement, so a driver can tell a real read from a floating bus.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the polarity, type and enable words read 0, the output is 0, and with all inputs low the raw status word at byte offset 0x0C reads 0x1F.
- R2: Byte offset 0x00 holds polarity, 0x04 holds type and 0x08 holds enable. Bit i of each word belongs to input i for i in 0..4, and bits 31:5 of these words read 0 whatever was written.
- R3: In level mode (type bit 0), raw status bit i equals input i when its polarity bit is 1 and the inverse of input i when it is 0. A change becomes readable at the second rising clock edge after it.
- R4: A read of byte offset 0x10 returns the raw status ANDed with the enable word.
- R5: A write to byte offset 0x0C sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R6: A write to byte offset 0x14 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged. A read of 0x14 returns 0.
- R7: In edge mode (type bit 1), an active edge sets the input's latch, and raw status then shows the latch. The active edge is rising when the polarity bit is 1 and falling when it is 0. The latch becomes readable at the third rising clock edge after the input changes, and it stays set after the input returns to its idle level.
- R8: A write of 1 to bit i at byte offset 0x10 clears input i's latch when that input is in edge mode. For an input in level mode, or for a data bit of 0, the write has no effect.
- R9: When an active edge is detected on the same clock edge that an acknowledge for that input is written, the latch stays set.
- R10: The interrupt output equals the OR of the enabled status bits, delayed by one clock cycle.
- R11: Byte offset 0x18 reads the input count 5 in bits 5:0. Byte offset 0x1C reads 0x0210A55A, laid out as major version 2 in bits 27:24, minor version 1 in bits 23:20, patch level 0 in bits 19:16, identifier 0x5A in bits 7:0 and its complement 0xA5 in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 5 | Interrupt request lines, asynchronous to clk |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address. Accesses that are not word-aligned are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
A corrupted polarity, type or enable bit shows at once in the word read back from its own offset. It also shows in the raw or enabled status two cycles after any input change. A stuck or spuriously set edge latch stays visible in the raw status word until acknowledged, so a single read after the input has returned to idle exposes it. A wrong enable or a missing output stage shows on the interrupt output one cycle after the enabled status changes, which is why that output is sampled both on the cycle of the write and on the cycle after it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // word indices within the register window (byte offset / 4)
  localparam int WORD_POL     = 0;
  localparam int WORD_TYPE    = 1;
  localparam int WORD_EN      = 2;
  localparam int WORD_RAW_SET = 3;  // read raw status, write enable-set
  localparam int WORD_ENA_ACK = 4;  // read enabled status, write acknowledge
  localparam int WORD_CLR     = 5;  // write enable-clear
  localparam int WORD_OPT     = 6;
  localparam int WORD_VER     = 7;

  localparam logic [3:0] VER_MAJOR = 4'd2;
  localparam logic [3:0] VER_MINOR = 4'd1;
  localparam logic [3:0] VER_PATCH = 4'd0;
  localparam logic [7:0] BLOCK_ID  = 8'h5A;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d, sync_d, sync_q;

  always_comb begin
    meta_d = d;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/irq_chan.sv
module irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic pol_high,
  input  logic edge_mode,
  input  logic ack,
  output logic raw
);
  logic lvl;
  logic prev_q, prev_d;
  logic latch_q, latch_d;
  logic hit;

  always_comb begin
    lvl     = pol_high ? sync_in : ~sync_in;
    hit     = lvl & ~prev_q;
    prev_d  = lvl;
    latch_d = latch_q;
    if (edge_mode) begin
      if (hit)      latch_d = 1'b1;   // a fresh edge beats a concurrent acknowledge
      else if (ack) latch_d = 1'b0;
    end
    raw = edge_mode ? latch_q : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      latch_q <= latch_d;
    end
  end

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && hit) |=> latch_q);  // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !hit) |=> !latch_q);  // R8

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode) |=> (latch_q == $past(latch_q)));  // R8
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int N      = 5,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      raw,
  output logic [DATA_W-1:0] rdata,
  output logic [N-1:0]      pol,
  output logic [N-1:0]      typ,
  output logic [N-1:0]      enabled,
  output logic [N-1:0]      ack
);
  localparam int IDX_W = ADDR_W - 2;

  logic [N-1:0]       pol_q, pol_d, typ_q, typ_d, en_q, en_d;
  logic [IDX_W-1:0]   idx;
  logic               aligned;
  logic               wr_hit;
  logic [N-1:0]       wbits;
  logic [DATA_W-N-1:0] unused_wdata_hi;

  assign idx             = addr[ADDR_W-1:2];
  assign aligned         = (addr[1:0] == 2'b00);
  assign wr_hit          = wr & aligned;
  assign wbits           = wdata[N-1:0];
  assign unused_wdata_hi = wdata[DATA_W-1:N];

  // next state
  always_comb begin
    pol_d = pol_q;
    typ_d = typ_q;
    en_d  = en_q;
    ack   = '0;
    if (wr_hit) begin
      if (idx == IDX_W'(WORD_POL))     pol_d = wbits;
      if (idx == IDX_W'(WORD_TYPE))    typ_d = wbits;
      if (idx == IDX_W'(WORD_EN))      en_d  = wbits;
      if (idx == IDX_W'(WORD_RAW_SET)) en_d  = en_q | wbits;
      if (idx == IDX_W'(WORD_CLR))     en_d  = en_q & ~wbits;
      if (idx == IDX_W'(WORD_ENA_ACK)) ack   = wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      typ_q <= '0;
      en_q  <= '0;
    end else begin
      pol_q <= pol_d;
      typ_q <= typ_d;
      en_q  <= en_d;
    end
  end

  assign pol     = pol_q;
  assign typ     = typ_q;
  assign enabled = raw & en_q;

  // read mux
  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (idx == IDX_W'(WORD_POL))     rdata = DATA_W'(pol_q);
      if (idx == IDX_W'(WORD_TYPE))    rdata = DATA_W'(typ_q);
      if (idx == IDX_W'(WORD_EN))      rdata = DATA_W'(en_q);
      if (idx == IDX_W'(WORD_RAW_SET)) rdata = DATA_W'(raw);
      if (idx == IDX_W'(WORD_ENA_ACK)) rdata = DATA_W'(enabled);
      if (idx == IDX_W'(WORD_OPT))     rdata = DATA_W'(6'(N));
      if (idx == IDX_W'(WORD_VER))
        rdata = DATA_W'({4'h0, VER_MAJOR, VER_MINOR, VER_PATCH, ~BLOCK_ID, BLOCK_ID});
    end
  end

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && idx == IDX_W'(WORD_RAW_SET)) |=>
      ((en_q & $past(wbits)) == $past(wbits)) && ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));  // R5

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && idx == IDX_W'(WORD_CLR)) |=>
      ((en_q & $past(wbits)) == '0) && ((en_q & ~$past(wbits)) == ($past(en_q) & ~$past(wbits))));  // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (idx <= IDX_W'(WORD_CLR)) |-> (rdata[DATA_W-1:N] == '0));  // R2
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N      = 5,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [1:0]   rst_pipe_q;
  logic         rst_n_int;
  logic [N-1:0] sync_lvl, raw, pol, typ, enabled, ack;
  logic         out_q, out_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  irq_sync #(.W(N)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .d(irq_in), .q(sync_lvl)
  );

  for (genvar g = 0; g < N; g++) begin : g_chan
    irq_chan u_chan (
      .clk(clk), .rst_n(rst_n_int), .sync_in(sync_lvl[g]), .pol_high(pol[g]),
      .edge_mode(typ[g]), .ack(ack[g]), .raw(raw[g])
    );
  end

  irq_regs #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .raw(raw), .rdata(bus_rdata), .pol(pol), .typ(typ), .enabled(enabled), .ack(ack)
  );

  always_comb out_d = |enabled;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) out_q <= 1'b0;
    else            out_q <= out_d;
  end
  assign irq_out = out_q;

  AST_OUT_LAG: assert property (@(posedge clk) disable iff (!rst_n_int)
    1'b1 |=> (irq_out == $past(|enabled)));  // R10
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  irq_in;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // fields: polarity, inputs, enable, expected raw, expected enabled, expected output
  localparam logic [25:0] VEC [6] = '{
    {5'b00000, 5'b00000, 5'b11111, 5'b11111, 5'b11111, 1'b1},
    {5'b11111, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 1'b0},
    {5'b11111, 5'b10101, 5'b00100, 5'b10101, 5'b00100, 1'b1},
    {5'b00000, 5'b11110, 5'b00001, 5'b00001, 5'b00001, 1'b1},
    {5'b01010, 5'b00101, 5'b01111, 5'b10000, 5'b00000, 1'b0},
    {5'b00110, 5'b00110, 5'b00000, 5'b11111, 5'b00000, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    rd(5'h00, rv); check("R1 pol", rv, 32'h0);
    rd(5'h04, rv); check("R1 type", rv, 32'h0);
    rd(5'h08, rv); check("R1 enable", rv, 32'h0);
    rd(5'h0C, rv); check("R1 raw", rv, 32'h1F);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R11 identification
    rd(5'h18, rv); check("R11 options", rv, 32'h5);
    rd(5'h1C, rv); check("R11 version", rv, 32'h0210A55A);
    check("R11 complement", {24'b0, rv[15:8]}, {24'b0, ~rv[7:0]});

    // R2 upper bits read zero
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, rv); check("R2 pol upper", rv, 32'h1F);
    wr(5'h04, 32'hFFFF_FFE0);
    rd(5'h04, rv); check("R2 type upper", rv, 32'h0);
    wr(5'h00, 32'h0);

    // R3 R4 R10 vector table, level mode
    foreach (VEC[i]) begin
      wr(5'h00, {27'b0, VEC[i][25:21]});
      wr(5'h08, {27'b0, VEC[i][15:11]});
      irq_in = VEC[i][20:16];
      step(4);
      rd(5'h0C, rv); check("R3 raw", rv, {27'b0, VEC[i][10:6]});
      rd(5'h10, rv); check("R4 enabled", rv, {27'b0, VEC[i][5:1]});
      check("R10 irq_out", {31'b0, irq_out}, {31'b0, VEC[i][0]});
    end

    // R3 synchronizer latency
    wr(5'h00, 32'h0); wr(5'h08, 32'h0);
    irq_in = 5'b00000; step(3);
    irq_in = 5'b00001; step(1);
    rd(5'h0C, rv); check("R3 one edge", rv, 32'h1F);
    step(1);
    rd(5'h0C, rv); check("R3 two edges", rv, 32'h1E);
    irq_in = 5'b00000; step(3);

    // R5 R6 aliases
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h05); rd(5'h08, rv); check("R5 set", rv, 32'h05);
    wr(5'h0C, 32'h02); rd(5'h08, rv); check("R5 set keeps", rv, 32'h07);
    wr(5'h14, 32'h04); rd(5'h08, rv); check("R6 clear", rv, 32'h03);
    rd(5'h14, rv); check("R6 read zero", rv, 32'h0);
    wr(5'h08, 32'h0); step(2);

    // R10 one-cycle lag
    wr(5'h0C, 32'h01);
    check("R10 lag low", {31'b0, irq_out}, 32'h0);
    step(1);
    check("R10 lag high", {31'b0, irq_out}, 32'h1);
    wr(5'h14, 32'h01);
    check("R10 lag hold", {31'b0, irq_out}, 32'h1);
    step(1);
    check("R10 lag drop", {31'b0, irq_out}, 32'h0);

    // R7 rising edge on input 0
    wr(5'h00, 32'h01); wr(5'h04, 32'h01); step(3);
    rd(5'h0C, rv); check("R7 idle", {31'b0, rv[0]}, 32'h0);
    irq_in[0] = 1'b1; step(2);
    rd(5'h0C, rv); check("R7 not yet", {31'b0, rv[0]}, 32'h0);
    step(1);
    rd(5'h0C, rv); check("R7 latched", {31'b0, rv[0]}, 32'h1);
    irq_in[0] = 1'b0; step(4);
    rd(5'h0C, rv); check("R7 held", {31'b0, rv[0]}, 32'h1);
    wr(5'h10, 32'h01);
    rd(5'h0C, rv); check("R8 ack clears", {31'b0, rv[0]}, 32'h0);

    // R7 falling edge on input 2
    wr(5'h04, 32'h05); step(3);
    irq_in[2] = 1'b1; step(4);
    rd(5'h0C, rv); check("R7 fall idle", {31'b0, rv[2]}, 32'h0);
    irq_in[2] = 1'b0; step(4);
    rd(5'h0C, rv); check("R7 fall latched", {31'b0, rv[2]}, 32'h1);
    wr(5'h10, 32'h04);
    rd(5'h0C, rv); check("R8 fall ack", {31'b0, rv[2]}, 32'h0);

    // R8 acknowledge ignored in level mode and for zero bits
    rd(5'h0C, rv); check("R8 level before", {31'b0, rv[1]}, 32'h1);
    wr(5'h10, 32'h02);
    rd(5'h0C, rv); check("R8 level ignore", {31'b0, rv[1]}, 32'h1);
    irq_in[0] = 1'b1; step(4); irq_in[0] = 1'b0; step(4);
    wr(5'h10, 32'h1E);
    rd(5'h0C, rv); check("R8 zero bit", {31'b0, rv[0]}, 32'h1);
    wr(5'h10, 32'h01); step(2);

    // R9 edge and acknowledge on the same clock edge
    irq_in[0] = 1'b1;
    step(1);
    wr(5'h10, 32'h01);
    rd(5'h0C, rv); check("R9 edge wins", {31'b0, rv[0]}, 32'h1);
    wr(5'h10, 32'h01);
    rd(5'h0C, rv); check("R8 later ack", {31'b0, rv[0]}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule